// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block carries out one atomic memory update per request: it reads a 32- or 64-bit word, combines it with a source operand, and writes the result back. The supported operations are add, or, and, xor, exchange and compare-and-exchange. A single-port memory interface carries the accesses. A lock output is held from the read request until the write is accepted, so that no other master can slip an access in between.

A request carries an opcode byte, a 32-bit operation immediate, the low address bits of the destination register, a signed 16-bit offset, the source register and R0. The opcode byte selects the access width. The immediate selects the operation, and its bit 0 asks for the old memory value to be returned. When the unit finishes it pulses `done_o` for one cycle. In that cycle it reports, zero-extended, either the value to load into the source register or the value to load into R0. If the opcode or immediate is illegal, it reports an error instead.

Top module: `amo_rmw_unit`

## Requirements
- R1: Only opcode 0xC3 (32-bit access) and opcode 0xDB (64-bit access) are legal. Any other opcode ends with `err_o`=1 in the done cycle, and no memory access takes place.
- R2: The legal immediates are these: 0x00/0x01 add, 0x40/0x41 or, 0x50/0x51 and, 0xA0/0xA1 xor, 0xE1 exchange, 0xF1 compare-and-exchange. Bit 0 is the fetch flag. Any other immediate, including 0xE0 and 0xF0, gives an error and no memory access.
- R3: Both accesses of an operation use the address `base + sign_extend(offset)`, truncated to ADDR_W bits.
- R4: A legal operation makes exactly one read and at most one write, in that order. `lock_o` is high whenever `mem_req_o` is high, and it stays high from the read request until the write is granted.
- R5: Add, or and and xor write `old op src` to memory. Add wraps.
- R6: When the fetch flag is set on add/or/and/xor/exchange, `src_wr_o`=1 and `src_val_o` is the old memory value. When the flag is clear, `src_wr_o`=0.
- R7: Exchange writes `src` to memory and returns the old value through `src_val_o`.
- R8: Compare-and-exchange writes `src` only if the old value equals R0. If it does not match, no write is issued. In both cases `r0_wr_o`=1, `r0_val_o` is the old value, and `src_wr_o`=0.
- R9: `mem_size_o`=1 marks a 64-bit access and 0 marks a 32-bit access. A 32-bit access uses only `mem_rdata_i[31:0]`, compares only the low 32 bits of R0, and drives `mem_wdata_o[63:32]` to zero. Its returned values are zero-extended.
- R10: `busy_o` rises in the cycle after a request is accepted and stays high through the done cycle. A request presented while busy is ignored.
- R11: `done_o` is a single-cycle pulse.
- R12: After reset `busy_o`, `lock_o`, `mem_req_o` and `done_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present (taken only when idle) |
| req_opcode_i | input | 8 | Opcode byte: access class, mode and size |
| req_imm_i | input | 32 | Operation immediate with fetch flag in bit 0 |
| req_base_i | input | ADDR_W | Destination register, low address bits |
| req_off_i | input | 16 | Signed address offset |
| req_src_i | input | 64 | Source register value |
| req_r0_i | input | 64 | R0 value (compare operand) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Request was illegal (valid with done_o) |
| src_wr_o | output | 1 | Load src_val_o into the source register |
| src_val_o | output | 64 | Old memory value, zero-extended |
| r0_wr_o | output | 1 | Load r0_val_o into R0 |
| r0_val_o | output | 64 | Old memory value, zero-extended |
| lock_o | output | 1 | Memory lock held for the read-write pair |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_size_o | output | 1 | 1 = 64-bit, 0 = 32-bit |
| mem_addr_o | output | ADDR_W | Access address |
| mem_wdata_o | output | 64 | Write data |
| mem_gnt_i | input | 1 | Memory accepted the request |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Read data |

## Verification
The assertions watch the lock and the sequencing on every cycle. They check that any request carries the lock, that the lock is not dropped between the read grant and the write grant, that an illegal request never reaches the memory, that `busy_o` holds until done, and that done is a single pulse. The operation values can only be shown by the bench's scenarios against its memory model. These include the compare hit and miss, the 32-bit masking against dirty upper bits, the negative offsets and the result zero-extension. Requests that arrive while the unit is busy are covered the same way.

// File: rtl/amo_pkg.sv
package amo_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_READ, ST_WAIT, ST_WRITE, ST_DONE} amo_state_e;
  typedef enum logic [2:0] {OP_ADD, OP_OR, OP_AND, OP_XOR, OP_XCHG, OP_CMPX} amo_op_e;
  localparam logic [2:0] CLS_STORE_REG = 3'h3;
  localparam logic [2:0] MODE_ATOMIC   = 3'h6;
  localparam logic [1:0] SZ_WORD       = 2'b00;
  localparam logic [1:0] SZ_DWORD      = 2'b11;
endpackage

// File: rtl/amo_decode.sv
module amo_decode
  import amo_pkg::*;
(
  input  logic [7:0]  opcode_i,
  input  logic [31:0] imm_i,
  output logic        legal_o,
  output logic        is64_o,
  output logic        fetch_o,
  output amo_op_e     op_o
);
  logic op_ok, imm_ok;

  assign op_ok  = (opcode_i[2:0] == CLS_STORE_REG) && (opcode_i[7:5] == MODE_ATOMIC) &&
                  ((opcode_i[4:3] == SZ_WORD) || (opcode_i[4:3] == SZ_DWORD));
  assign is64_o  = (opcode_i[4:3] == SZ_DWORD);
  assign fetch_o = imm_i[0];

  always_comb begin
    imm_ok = (imm_i[31:8] == '0);
    op_o   = OP_ADD;
    unique case (imm_i[7:0])
      8'h00, 8'h01: op_o = OP_ADD;
      8'h40, 8'h41: op_o = OP_OR;
      8'h50, 8'h51: op_o = OP_AND;
      8'ha0, 8'ha1: op_o = OP_XOR;
      8'he1:        op_o = OP_XCHG;
      8'hf1:        op_o = OP_CMPX;
      default:      imm_ok = 1'b0;
    endcase
  end

  assign legal_o = op_ok && imm_ok;
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  amo_op_e           op_i,
  input  logic              is64_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] r0_i,
  output logic [DATA_W-1:0] old_o,
  output logic [DATA_W-1:0] new_o,
  output logic              do_write_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] mask, b, res;

  assign mask  = is64_i ? {DATA_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
  assign old_o = rdata_i & mask;
  assign b     = src_i & mask;

  always_comb begin
    unique case (op_i)
      OP_ADD:  res = old_o + b;
      OP_OR:   res = old_o | b;
      OP_AND:  res = old_o & b;
      OP_XOR:  res = old_o ^ b;
      default: res = b;
    endcase
  end

  assign new_o      = res & mask;
  // failed compare suppresses the write
  assign do_write_o = (op_i != OP_CMPX) || (old_o == (r0_i & mask));
endmodule

// File: rtl/amo_rmw_unit.sv
module amo_rmw_unit
  import amo_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int OFF_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [7:0]        req_opcode_i,
  input  logic [31:0]       req_imm_i,
  input  logic [ADDR_W-1:0] req_base_i,
  input  logic [OFF_W-1:0]  req_off_i,
  input  logic [DATA_W-1:0] req_src_i,
  input  logic [DATA_W-1:0] req_r0_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              src_wr_o,
  output logic [DATA_W-1:0] src_val_o,
  output logic              r0_wr_o,
  output logic [DATA_W-1:0] r0_val_o,
  output logic              lock_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_size_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int EXT_W = ADDR_W - OFF_W;

  amo_state_e        state_q;
  amo_op_e           op_q, dec_op;
  logic              is64_q, fetch_q, err_q;
  logic              dec_legal, dec_is64, dec_fetch;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] src_q, r0_q, old_q, new_q;
  logic [DATA_W-1:0] alu_old, alu_new;
  logic              alu_wr;

  amo_decode u_dec (
    .opcode_i (req_opcode_i),
    .imm_i    (req_imm_i),
    .legal_o  (dec_legal),
    .is64_o   (dec_is64),
    .fetch_o  (dec_fetch),
    .op_o     (dec_op)
  );

  amo_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i       (op_q),
    .is64_i     (is64_q),
    .rdata_i    (mem_rdata_i),
    .src_i      (src_q),
    .r0_i       (r0_q),
    .old_o      (alu_old),
    .new_o      (alu_new),
    .do_write_o (alu_wr)
  );

  assign addr_d = req_base_i + {{EXT_W{req_off_i[OFF_W-1]}}, req_off_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_ADD;
      is64_q  <= 1'b0;
      fetch_q <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      src_q   <= '0;
      r0_q    <= '0;
      old_q   <= '0;
      new_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          op_q    <= dec_op;
          is64_q  <= dec_is64;
          fetch_q <= dec_fetch;
          err_q   <= !dec_legal;
          addr_q  <= addr_d;
          src_q   <= req_src_i;
          r0_q    <= req_r0_i;
          old_q   <= '0;
          state_q <= dec_legal ? ST_READ : ST_DONE;
        end
        ST_READ:  if (mem_gnt_i) state_q <= ST_WAIT;
        ST_WAIT:  if (mem_rvalid_i) begin
          old_q   <= alu_old;
          new_q   <= alu_new;
          state_q <= alu_wr ? ST_WRITE : ST_DONE;
        end
        ST_WRITE: if (mem_gnt_i) state_q <= ST_DONE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign err_o       = done_o && err_q;
  assign mem_req_o   = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_we_o    = (state_q == ST_WRITE);
  assign lock_o      = (state_q == ST_READ) || (state_q == ST_WAIT) || (state_q == ST_WRITE);
  assign mem_size_o  = is64_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = new_q;
  assign src_wr_o    = done_o && !err_q && fetch_q && (op_q != OP_CMPX);
  assign r0_wr_o     = done_o && !err_q && (op_q == OP_CMPX);
  assign src_val_o   = old_q;
  assign r0_val_o    = old_q;

  AST_REQ_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> lock_o); // R4
  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && !(mem_we_o && mem_gnt_i) && !(!mem_req_o && mem_rvalid_i)) |=> lock_o); // R4
  AST_ERR_NO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i && !dec_legal) |=> (!mem_req_o && !lock_o)); // R1
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_NARROW_WDATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !mem_size_o) |-> (mem_wdata_o[DATA_W-1:DATA_W/2] == '0)); // R9
  AST_ONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(src_wr_o && r0_wr_o)); // R8
endmodule

// File: tb/amo_rmw_unit_bench.sv
module amo_rmw_unit_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 0;
  logic [7:0]  req_opcode = 0;
  logic [31:0] req_imm = 0, req_base = 0;
  logic [15:0] req_off = 0;
  logic [63:0] req_src = 0, req_r0 = 0;
  logic busy, done, err, src_wr, r0_wr, lock, mreq, mwe, msize;
  logic [63:0] src_val, r0_val, mwdata;
  logic [31:0] maddr;
  logic        mgnt = 0, mrvalid = 0;
  logic [63:0] mrdata = 0;

  amo_rmw_unit u_amo_rmw_unit (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_opcode_i(req_opcode),
    .req_imm_i(req_imm), .req_base_i(req_base), .req_off_i(req_off), .req_src_i(req_src),
    .req_r0_i(req_r0), .busy_o(busy), .done_o(done), .err_o(err), .src_wr_o(src_wr),
    .src_val_o(src_val), .r0_wr_o(r0_wr), .r0_val_o(r0_val), .lock_o(lock),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_size_o(msize), .mem_addr_o(maddr),
    .mem_wdata_o(mwdata), .mem_gnt_i(mgnt), .mem_rvalid_i(mrvalid), .mem_rdata_i(mrdata)
  );

  int vectors = 0, miscompares = 0;
  logic [63:0] mem [logic [31:0]];
  int rd_cnt = 0, wr_cnt = 0, stall_cfg = 0, stall_left = 0;
  logic [31:0] rd_addr = 0, last_addr = 0;
  bit rd_pend = 0, lock_win = 0, prev_done = 0;

  function automatic logic [63:0] rdm(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model and per-clock protocol checks
  always @(negedge clk) begin
    if (rst_n) begin
      mrvalid = rd_pend;
      mrdata  = rd_pend ? rdm(rd_addr) : 64'h0;
      rd_pend = 0;
      mgnt    = 0;
      if (done) lock_win = 0;
      if (mreq) chk("R4 lock with request", {63'h0, lock}, 64'h1);
      if (lock_win) chk("R4 lock held", {63'h0, lock}, 64'h1);
      if (prev_done) chk("R11 done pulse", {63'h0, done}, 64'h0);
      prev_done = done;
      if (!mreq) stall_left = stall_cfg;
      else if (stall_left > 0) stall_left--;
      else begin
        mgnt = 1;
        last_addr = maddr;
        if (mwe) begin
          if (!msize) chk("R9 narrow wdata upper", mwdata[63:32], 64'h0);
          mem[maddr] = msize ? mwdata : {rdm(maddr)[63:32], mwdata[31:0]};
          wr_cnt++;
          lock_win = 0;
        end else begin
          rd_pend = 1;
          rd_addr = maddr;
          rd_cnt++;
          lock_win = 1;
        end
      end
    end
  end

  task automatic do_op(input string tag, input logic [7:0] opc, input logic [31:0] imm,
                       input logic [31:0] base, input logic [15:0] off,
                       input logic [63:0] src, input logic [63:0] r0,
                       input int stall, input bit poke);
    bit legal, w64, hit, wr_exp, fetch;
    logic [63:0] m, orig, old, nv, exp_mem;
    logic [31:0] a;
    int rd0, wr0, n;
    bit seen;
    w64   = (opc == 8'hdb);
    legal = ((opc == 8'hc3) || w64) &&
            (imm inside {32'h00, 32'h01, 32'h40, 32'h41, 32'h50, 32'h51,
                         32'ha0, 32'ha1, 32'he1, 32'hf1});
    fetch = imm[0];
    m     = w64 ? 64'hffff_ffff_ffff_ffff : 64'h0000_0000_ffff_ffff;
    a     = base + {{16{off[15]}}, off};
    orig  = rdm(a);
    old   = orig & m;
    case (imm[7:4])
      4'h0: nv = (old + src) & m;
      4'h4: nv = (old | src) & m;
      4'h5: nv = (old & src) & m;
      4'ha: nv = (old ^ src) & m;
      default: nv = src & m;
    endcase
    hit     = (old == (r0 & m));
    wr_exp  = legal && ((imm != 32'hf1) || hit);
    exp_mem = !wr_exp ? orig : (w64 ? nv : {orig[63:32], nv[31:0]});
    rd0 = rd_cnt; wr0 = wr_cnt;
    stall_cfg = stall;
    req_valid = 1; req_opcode = opc; req_imm = imm; req_base = base;
    req_off = off; req_src = src; req_r0 = r0;
    @(negedge clk);
    chk({tag, " R10 busy after accept"}, {63'h0, busy}, 64'h1);
    if (poke) begin
      req_opcode = 8'hdb; req_imm = 32'he1; req_base = base + 32'h100; req_src = 64'hdead;
    end else req_valid = 0;
    seen = 0;
    for (n = 0; n < 40 && !seen; n++) begin
      if (done) seen = 1; else @(negedge clk);
    end
    req_valid = 0;
    chk({tag, " R11 done seen"}, {63'h0, seen}, 64'h1);
    chk({tag, " R1 R2 err"}, {63'h0, err}, {63'h0, !legal});
    chk({tag, " R6 R7 src_wr"}, {63'h0, src_wr}, {63'h0, legal && fetch && imm != 32'hf1});
    if (legal && fetch && imm != 32'hf1) chk({tag, " R6 src_val"}, src_val, old);
    chk({tag, " R8 r0_wr"}, {63'h0, r0_wr}, {63'h0, legal && imm == 32'hf1});
    if (legal && imm == 32'hf1) chk({tag, " R8 r0_val"}, r0_val, old);
    chk({tag, " R4 read count"}, 64'(rd_cnt - rd0), legal ? 64'd1 : 64'd0);
    chk({tag, " R4 R8 write count"}, 64'(wr_cnt - wr0), wr_exp ? 64'd1 : 64'd0);
    if (legal) chk({tag, " R3 address"}, {32'h0, last_addr}, {32'h0, a});
    chk({tag, " R5 memory"}, rdm(a), exp_mem);
    if (poke) chk({tag, " R10 poke untouched"}, rdm(base + 32'h100), 64'h5555);
    @(negedge clk);
    chk({tag, " R10 idle after done"}, {63'h0, busy}, 64'h0);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    mem[32'h1000] = 64'h0000_0001_ffff_fff0;
    mem[32'h1100] = 64'h5555;
    mem[32'h2000] = 64'habcd_ef01_8000_0001;
    mem[32'h0ff8] = 64'hf0f0_f0f0_0f0f_0f0f;
    mem[32'h3000] = 64'h1234_5678_9abc_def0;
    repeat (3) @(negedge clk);
    chk("R12 busy", {63'h0, busy}, 64'h0);
    chk("R12 lock", {63'h0, lock}, 64'h0);
    chk("R12 mem_req", {63'h0, mreq}, 64'h0);
    chk("R12 done", {63'h0, done}, 64'h0);
    rst_n = 1;
    @(negedge clk);
    do_op("add64",      8'hdb, 32'h00, 32'h1000, 16'h0000, 64'h20, 0, 0, 0);
    do_op("add64f",     8'hdb, 32'h01, 32'h1000, 16'h0000, 64'hffff_ffff_ffff_ffff, 0, 2, 0);
    do_op("or32f R9",   8'hc3, 32'h41, 32'h2000, 16'h0000, 64'hffff_0000_0000_0100, 0, 1, 0);
    do_op("and64neg R3", 8'hdb, 32'h51, 32'h1000, 16'hfff8, 64'hff00_ff00_ff00_ff00, 0, 0, 0);
    do_op("xor32",      8'hc3, 32'ha0, 32'h3000, 16'h0000, 64'h0000_0000_ffff_ffff, 0, 0, 0);
    do_op("xchg64 R7",  8'hdb, 32'he1, 32'h3000, 16'h0000, 64'h7777_8888_9999_aaaa, 0, 3, 0);
    do_op("cmpx hit R8", 8'hdb, 32'hf1, 32'h3000, 16'h0000, 64'h42, 64'h7777_8888_9999_aaaa, 0, 0);
    do_op("cmpx miss R8", 8'hdb, 32'hf1, 32'h3000, 16'h0000, 64'h99, 64'h43, 1, 0);
    do_op("cmpx32 R9",  8'hc3, 32'hf1, 32'h2000, 16'h0000, 64'h0bad_0000_1234_5678,
          64'hffff_ffff_8000_0101, 0, 0);
    do_op("byte op R1", 8'hd3, 32'h00, 32'h1000, 16'h0000, 64'h1, 0, 0, 0);
    do_op("half op R1", 8'hcb, 32'h01, 32'h1000, 16'h0000, 64'h1, 0, 0, 0);
    do_op("imm 02 R2",  8'hdb, 32'h02, 32'h1000, 16'h0000, 64'h1, 0, 0, 0);
    do_op("imm e0 R2",  8'hdb, 32'he0, 32'h1000, 16'h0000, 64'h1, 0, 0, 0);
    do_op("imm hi R2",  8'hc3, 32'h100, 32'h1000, 16'h0000, 64'h1, 0, 0, 0);
    do_op("poke R10",   8'hdb, 32'h01, 32'h1000, 16'h0000, 64'h3, 0, 2, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule